// File: doc/BRIEF.md
# Paced Write Payload Packetizer

This block carries the payload phase of a block write towards a serial tape drive. Once the write command has gone out, the controller hands the block a total byte count with a one-cycle start strobe. The block then waits for the drive to say "continue" before each packet. It splits the payload into packets of at most 128 bytes and sends each one to the transmitter as a flag byte, a length byte, the payload and a 16-bit checksum. Payload bytes come from a ready/valid byte source and go straight through to a ready/valid transmitter. The checksum is built up while the bytes pass, so it is complete by the time the payload has gone.

While it waits for a continue byte, the block also watches for the drive ending the transfer early, asking for a full reinitialisation, or sending something it cannot make sense of. On every exit it raises `done` for one cycle with the number of payload bytes in fully sent packets, so the controller can report a residual count. It also pulses exactly one exit line: a hand-off to the end-packet receiver, a reinitialisation request or a protocol-fault request.

Top module: `wrPacketizer`

## Requirements
- R1: After a start with a nonzero total, `busy` is high from the next cycle, and no byte is offered to the transmitter until a continue byte (0x10) is received while waiting.
- R2: Each packet is sent as flag 0x01, then a length byte equal to the smaller of 128 and the bytes still remaining, then that many payload bytes in source order, then the checksum low byte followed by the high byte.
- R3: The checksum is a 16-bit end-around-carry sum of these words: the header word (flag in the low byte, length in the high byte) and the payload words. In a payload word, the byte at the even offset is the low byte and the byte at the odd offset is the high byte. An odd final byte counts as a word with a zero high byte.
- R4: The source is read only while a payload byte is due: `srcReady` equals `txReady` in that phase and is low otherwise, and `txValid` follows `srcValid` in that phase.
- R5: After a checksum is accepted, the remaining count drops by that packet's length. If bytes remain, the block waits for the next continue byte. Every `done` pulse carries in `sentCount` the total length of the packets already completed.
- R6: When no bytes remain after a checksum, the next cycle shows `respStart` and `done` high and `respPreloaded` low, and the block is idle.
- R7: A 0x02 byte received while waiting gives `respStart` and `respPreloaded` high together with `done` on the next cycle, and the block goes idle.
- R8: A 0x04 byte received while waiting gives a one-cycle `reinitReq` together with `done`, and the block goes idle.
- R9: Any other byte received while waiting gives a one-cycle `faultReq` together with `done`, and the block goes idle.
- R10: Received bytes outside the waiting state, and `start` while busy, have no effect on the transmitted stream or the outputs.
- R11: A start with a zero total sends no bytes. On the next cycle it gives `respStart` and `done` with `sentCount` 0, and `busy` stays low.
- R12: During reset the block is idle: `busy`, `txValid`, `srcReady` and all pulse outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a payload phase (used only when idle) |
| totalCount | input | CNT_W | Total payload bytes, sampled with start |
| srcValid | input | 1 | Payload source has a byte |
| srcData | input | 8 | Payload byte |
| srcReady | output | 1 | Payload byte taken this cycle |
| txValid | output | 1 | Byte offered to transmitter |
| txData | output | 8 | Byte to transmit |
| txReady | input | 1 | Transmitter accepts the byte |
| rxValid | input | 1 | A byte arrived from the drive |
| rxData | input | 8 | Received byte |
| busy | output | 1 | Payload phase in progress |
| respStart | output | 1 | Pulse: end-packet receiver takes over |
| respPreloaded | output | 1 | With respStart: the 0x02 flag byte has already been received |
| reinitReq | output | 1 | Pulse: full reinitialisation requested |
| faultReq | output | 1 | Pulse: unexpected byte, controller returns to init |
| done | output | 1 | Pulse: payload phase ended |
| sentCount | output | CNT_W | Bytes in completed packets, valid with done |

## Verification
The assertions check on every cycle the properties that do not depend on history: the transmitter stays quiet while idle, the source is only drained into an accepting transmitter, exactly one exit line fires with each `done`, the preloaded flag never appears without the hand-off, and the block is idle whenever `done` rises. Packet bytes, chunk lengths, checksum values and the counts carried on `done` depend on the whole sequence of continue bytes and stalls. Only the bench's reference model can show them, by following every byte through random back-pressure. The same holds for early-end, reinitialisation and fault exits taken partway through a transfer.

// File: rtl/wpsPkg.sv
package wpsPkg;

  // received control bytes and the data packet flag
  localparam logic [7:0] FLAG_DATA = 8'h01;
  localparam logic [7:0] FLAG_CMD  = 8'h02;
  localparam logic [7:0] FLAG_INIT = 8'h04;
  localparam logic [7:0] FLAG_CONT = 8'h10;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_FLAG,
    SEL_COUNT,
    SEL_PAY,
    SEL_CKLO,
    SEL_CKHI
  } txSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic   loadJob;
    logic   loadPkt;
    logic   payXfer;
    logic   pktDone;
    txSel_e sel;
  } dpStrobe_t;

endpackage

// File: rtl/wpsDatapath.sv
module wpsDatapath
  import wpsPkg::*;
#(
  parameter int CNT_W = 16,
  parameter int CHUNK = 128
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strb,
  input  logic [CNT_W-1:0] totalCount,
  input  logic             srcValid,
  input  logic [7:0]       srcData,
  input  logic             txReady,
  output logic             srcReady,
  output logic             txValid,
  output logic [7:0]       txData,
  output logic             txFire,
  output logic             lastPay,
  output logic             finalPkt,
  output logic             totalZero,
  output logic [CNT_W-1:0] sentCount
);

  localparam logic [CNT_W-1:0] CHUNK_C = CNT_W'(CHUNK);
  localparam logic [7:0]       CHUNK_B = 8'(CHUNK);

  logic [CNT_W-1:0] remaining;
  logic [CNT_W-1:0] sent;
  logic [7:0]       pktLen;
  logic [7:0]       payIdx;
  logic [15:0]      cksum;
  logic [7:0]       pktLenNext;
  logic [15:0]      payWord;

  function automatic logic [15:0] addFold(input logic [15:0] a, input logic [15:0] b);
    logic [16:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[15:0] + {15'b0, s[16]};
  endfunction

  assign pktLenNext = (remaining >= CHUNK_C) ? CHUNK_B : remaining[7:0];
  assign payWord    = payIdx[0] ? {srcData, 8'h00} : {8'h00, srcData};
  assign lastPay    = (payIdx == pktLen - 8'd1);
  assign finalPkt   = (remaining == CNT_W'(pktLen));
  assign totalZero  = (totalCount == '0);
  assign sentCount  = sent;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remaining <= '0;
      sent      <= '0;
      pktLen    <= '0;
      payIdx    <= '0;
      cksum     <= '0;
    end else begin
      if (strb.loadJob) begin
        remaining <= totalCount;
        sent      <= '0;
      end
      if (strb.loadPkt) begin
        pktLen <= pktLenNext;
        payIdx <= '0;
        cksum  <= {pktLenNext, FLAG_DATA};
      end
      if (strb.payXfer) begin
        payIdx <= payIdx + 8'd1;
        cksum  <= addFold(cksum, payWord);
      end
      if (strb.pktDone) begin
        remaining <= remaining - CNT_W'(pktLen);
        sent      <= sent + CNT_W'(pktLen);
      end
    end
  end

  always_comb begin
    txValid = 1'b0;
    txData  = 8'h00;
    unique case (strb.sel)
      SEL_FLAG:  begin txValid = 1'b1;     txData = FLAG_DATA;    end
      SEL_COUNT: begin txValid = 1'b1;     txData = pktLen;       end
      SEL_PAY:   begin txValid = srcValid; txData = srcData;      end
      SEL_CKLO:  begin txValid = 1'b1;     txData = cksum[7:0];   end
      SEL_CKHI:  begin txValid = 1'b1;     txData = cksum[15:8];  end
      default:   begin txValid = 1'b0;     txData = 8'h00;        end
    endcase
  end

  assign srcReady = (strb.sel == SEL_PAY) && txReady;
  assign txFire   = txValid && txReady;

endmodule

// File: rtl/wpsCtrl.sv
module wpsCtrl
  import wpsPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       totalZero,
  input  logic       rxValid,
  input  logic [7:0] rxData,
  input  logic       txFire,
  input  logic       lastPay,
  input  logic       finalPkt,
  output dpStrobe_t  strb,
  output logic       busy,
  output logic       respStart,
  output logic       respPreloaded,
  output logic       reinitReq,
  output logic       faultReq,
  output logic       done
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_WAIT, ST_FLAG, ST_COUNT, ST_PAY, ST_CKLO, ST_CKHI
  } state_e;

  state_e state, nxt;
  logic   exResp, exPre, exReinit, exFault;

  always_comb begin
    nxt      = state;
    strb     = '{loadJob: 1'b0, loadPkt: 1'b0, payXfer: 1'b0, pktDone: 1'b0, sel: SEL_NONE};
    exResp   = 1'b0;
    exPre    = 1'b0;
    exReinit = 1'b0;
    exFault  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          strb.loadJob = 1'b1;
          if (totalZero) exResp = 1'b1;
          else           nxt    = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (rxValid) begin
          unique case (rxData)
            FLAG_CONT: begin strb.loadPkt = 1'b1; nxt = ST_FLAG; end
            FLAG_CMD:  begin exResp = 1'b1; exPre = 1'b1; nxt = ST_IDLE; end
            FLAG_INIT: begin exReinit = 1'b1; nxt = ST_IDLE; end
            default:   begin exFault = 1'b1; nxt = ST_IDLE; end
          endcase
        end
      end
      ST_FLAG: begin
        strb.sel = SEL_FLAG;
        if (txFire) nxt = ST_COUNT;
      end
      ST_COUNT: begin
        strb.sel = SEL_COUNT;
        if (txFire) nxt = ST_PAY;
      end
      ST_PAY: begin
        strb.sel = SEL_PAY;
        if (txFire) begin
          strb.payXfer = 1'b1;
          if (lastPay) nxt = ST_CKLO;
        end
      end
      ST_CKLO: begin
        strb.sel = SEL_CKLO;
        if (txFire) nxt = ST_CKHI;
      end
      ST_CKHI: begin
        strb.sel = SEL_CKHI;
        if (txFire) begin
          strb.pktDone = 1'b1;
          if (finalPkt) begin
            exResp = 1'b1;
            nxt    = ST_IDLE;
          end else begin
            nxt = ST_WAIT;
          end
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state         <= ST_IDLE;
      respStart     <= 1'b0;
      respPreloaded <= 1'b0;
      reinitReq     <= 1'b0;
      faultReq      <= 1'b0;
      done          <= 1'b0;
    end else begin
      state         <= nxt;
      respStart     <= exResp;
      respPreloaded <= exPre;
      reinitReq     <= exReinit;
      faultReq      <= exFault;
      done          <= exResp | exReinit | exFault;
    end
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/wrPacketizer.sv
module wrPacketizer
  import wpsPkg::*;
#(
  parameter int CNT_W = 16,
  parameter int CHUNK = 128
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [CNT_W-1:0] totalCount,
  input  logic             srcValid,
  input  logic [7:0]       srcData,
  output logic             srcReady,
  output logic             txValid,
  output logic [7:0]       txData,
  input  logic             txReady,
  input  logic             rxValid,
  input  logic [7:0]       rxData,
  output logic             busy,
  output logic             respStart,
  output logic             respPreloaded,
  output logic             reinitReq,
  output logic             faultReq,
  output logic             done,
  output logic [CNT_W-1:0] sentCount
);

  dpStrobe_t strb;
  logic      txFire, lastPay, finalPkt, totalZero;

  wpsCtrl ctrl_i (
    .clk(clk), .rstN(rstN), .start(start), .totalZero(totalZero),
    .rxValid(rxValid), .rxData(rxData), .txFire(txFire),
    .lastPay(lastPay), .finalPkt(finalPkt), .strb(strb), .busy(busy),
    .respStart(respStart), .respPreloaded(respPreloaded),
    .reinitReq(reinitReq), .faultReq(faultReq), .done(done)
  );

  wpsDatapath #(.CNT_W(CNT_W), .CHUNK(CHUNK)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .totalCount(totalCount),
    .srcValid(srcValid), .srcData(srcData), .txReady(txReady),
    .srcReady(srcReady), .txValid(txValid), .txData(txData),
    .txFire(txFire), .lastPay(lastPay), .finalPkt(finalPkt),
    .totalZero(totalZero), .sentCount(sentCount)
  );

endmodule

// File: rtl/wrPacketizerChecker.sv
module wrPacketizerChecker (
  input logic clk,
  input logic rstN,
  input logic start,
  input logic srcReady,
  input logic txValid,
  input logic txReady,
  input logic busy,
  input logic respStart,
  input logic respPreloaded,
  input logic reinitReq,
  input logic faultReq,
  input logic done
);

  // R1: nothing offered while idle
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !txValid);

  // R1: a new payload phase only begins from a start strobe
  assert_busy_from_start_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(start));

  // R4: source drained only into an accepting transmitter
  assert_src_into_tx_R4: assert property (@(posedge clk) disable iff (!rstN)
    srcReady |-> (txReady && busy));

  // R6/R8/R9: at most one exit line at a time
  assert_one_exit_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({respStart, reinitReq, faultReq}));

  // R6: done is always accompanied by an exit line
  assert_done_has_exit_R6: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (respStart || reinitReq || faultReq));

  // R7: preloaded flag only with the hand-off
  assert_preload_with_resp_R7: assert property (@(posedge clk) disable iff (!rstN)
    respPreloaded |-> respStart);

  // R8: the block is idle when an exit is reported
  assert_idle_at_done_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

endmodule

bind wrPacketizer wrPacketizerChecker chk_i (
  .clk(clk), .rstN(rstN), .start(start), .srcReady(srcReady),
  .txValid(txValid), .txReady(txReady), .busy(busy),
  .respStart(respStart), .respPreloaded(respPreloaded),
  .reinitReq(reinitReq), .faultReq(faultReq), .done(done)
);

// File: tb/wrPacketizer_tb_top.sv
`timescale 1ns/1ps
module wrPacketizer_tb_top;

  localparam int CHUNK = 128;
  localparam int WD    = 150000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [15:0] totalCount = '0;
  logic        srcValid = 1'b0;
  logic [7:0]  srcData = '0;
  logic        srcReady;
  logic        txValid;
  logic [7:0]  txData;
  logic        txReady = 1'b0;
  logic        rxValid = 1'b0;
  logic [7:0]  rxData = '0;
  logic        busy, respStart, respPreloaded, reinitReq, faultReq, done;
  logic [15:0] sentCount;

  always #10 clk = ~clk;

  wrPacketizer dut_i (
    .clk(clk), .rstN(rstN), .start(start), .totalCount(totalCount),
    .srcValid(srcValid), .srcData(srcData), .srcReady(srcReady),
    .txValid(txValid), .txData(txData), .txReady(txReady),
    .rxValid(rxValid), .rxData(rxData), .busy(busy),
    .respStart(respStart), .respPreloaded(respPreloaded),
    .reinitReq(reinitReq), .faultReq(faultReq), .done(done),
    .sentCount(sentCount)
  );

  int compared = 0;
  int mismatched = 0;
  int cyc = 0;
  bit summaryDone = 0;

  // scenario controls
  bit startReq = 0;
  int startTotal = 0;
  bit busyStartReq = 0;
  bit noiseOn = 0;
  byte unsigned rxQ[$];

  // reference model state
  int mState = 0;          // 0 idle, 1 waiting, 2 sending
  int mRem = 0;
  int mSent = 0;
  int srcIdx = 0;
  byte unsigned pktQ[$];
  int kindQ[$];            // 0 header, 1 payload, 2 checksum
  bit eResp = 0, ePre = 0, eReinit = 0, eFault = 0, eDone = 0;

  // observation counters
  int txSeen = 0, doneSeen = 0, reinitSeen = 0, faultSeen = 0, preSeen = 0;
  int lastSent = -1;

  function automatic byte unsigned payByte(input int i);
    return 8'((i * 37 + 11) ^ (i >> 3));
  endfunction

  function automatic int foldAdd(input int a, input int b);
    int s;
    s = a + b;
    if (s > 16'hFFFF) s = (s & 16'hFFFF) + 1;
    return s;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s actual %0h expected %0h (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  task automatic summary();
    if (!summaryDone) begin
      summaryDone = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    end
  endtask

  task automatic buildPacket();
    int len, s;
    len = (mRem >= CHUNK) ? CHUNK : mRem;
    pktQ.push_back(8'h01); kindQ.push_back(0);
    pktQ.push_back(8'(len)); kindQ.push_back(0);
    s = 1 | (len << 8);
    for (int k = 0; k < len; k++) begin
      pktQ.push_back(payByte(srcIdx + k)); kindQ.push_back(1);
    end
    for (int k = 0; k < len; k += 2) begin
      int w;
      w = payByte(srcIdx + k);
      if (k + 1 < len) w = w | (int'(payByte(srcIdx + k + 1)) << 8);
      s = foldAdd(s, w);
    end
    pktQ.push_back(8'(s & 8'hFF)); kindQ.push_back(2);
    pktQ.push_back(8'((s >> 8) & 8'hFF)); kindQ.push_back(2);
  endtask

  // per-cycle driver, comparator and model
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (cyc > WD) begin
        mismatched++;
        $display("FAIL watchdog expired: actual cycle %0d expected below %0d", cyc, WD);
        summary();
        $finish;
      end
      txReady  = ($urandom % 4) != 0;
      srcValid = ($urandom % 5) != 0;
      srcData  = payByte(srcIdx);
      start    = 1'b0;
      if (startReq) begin
        start = 1'b1; totalCount = 16'(startTotal); startReq = 0;
      end else if (busyStartReq && mState != 0) begin
        start = 1'b1; totalCount = 16'd7; busyStartReq = 0;
      end
      rxValid = 1'b0; rxData = 8'h00;
      if (mState == 1 && rxQ.size() > 0 && ($urandom % 2) == 0) begin
        rxValid = 1'b1; rxData = rxQ.pop_front();
      end else if (mState != 1 && noiseOn && ($urandom % 3) == 0) begin
        rxValid = 1'b1; rxData = 8'h04;
      end
      #2;
      if (rstN) begin
        bit expTxV, expSrcR, fire;
        bit nResp, nPre, nReinit, nFault, nDone;
        string dtag;
        expTxV  = (pktQ.size() > 0) && ((kindQ[0] == 1) ? srcValid : 1'b1);
        expSrcR = (pktQ.size() > 0) && (kindQ[0] == 1) && txReady;
        dtag    = (pktQ.size() > 0 && kindQ[0] == 2) ? "R3" : "R2";
        // R1 busy, R2/R3 bytes, R4 source handshake
        chk(busy == (mState != 0), "R1", "busy", busy, mState != 0);
        chk(txValid == expTxV, "R2", "txValid", txValid, expTxV);
        if (expTxV) chk(txData == pktQ[0], dtag, "txData", txData, pktQ[0]);
        chk(srcReady == expSrcR, "R4", "srcReady", srcReady, expSrcR);
        // R6..R9 exits, R5 counts
        chk(respStart == eResp, "R6", "respStart", respStart, eResp);
        chk(respPreloaded == ePre, "R7", "respPreloaded", respPreloaded, ePre);
        chk(reinitReq == eReinit, "R8", "reinitReq", reinitReq, eReinit);
        chk(faultReq == eFault, "R9", "faultReq", faultReq, eFault);
        chk(done == eDone, "R5", "done", done, eDone);
        if (eDone) chk(sentCount == 16'(mSent), "R5", "sentCount", sentCount, mSent);
        if (txValid && txReady) txSeen++;
        if (done) begin doneSeen++; lastSent = sentCount; end
        if (reinitReq) reinitSeen++;
        if (faultReq) faultSeen++;
        if (respPreloaded) preSeen++;
        // model step for the coming edge
        nResp = 0; nPre = 0; nReinit = 0; nFault = 0; nDone = 0;
        case (mState)
          0: if (start) begin
               mSent = 0;
               if (totalCount == 0) begin nResp = 1; nDone = 1; end
               else begin mRem = totalCount; mState = 1; end
             end
          1: if (rxValid) begin
               case (rxData)
                 8'h10: begin buildPacket(); mState = 2; end
                 8'h02: begin nResp = 1; nPre = 1; nDone = 1; mState = 0; end
                 8'h04: begin nReinit = 1; nDone = 1; mState = 0; end
                 default: begin nFault = 1; nDone = 1; mState = 0; end
               endcase
             end
          default: begin
            fire = expTxV && txReady;
            if (fire) begin
              int len;
              if (kindQ[0] == 1) srcIdx++;
              void'(pktQ.pop_front());
              void'(kindQ.pop_front());
              if (pktQ.size() == 0) begin
                len = (mRem >= CHUNK) ? CHUNK : mRem;
                mRem -= len;
                mSent += len;
                if (mRem == 0) begin nResp = 1; nDone = 1; mState = 0; end
                else mState = 1;
              end
            end
          end
        endcase
        eResp = nResp; ePre = nPre; eReinit = nReinit; eFault = nFault; eDone = nDone;
      end
    end
  end

  task automatic runJob(input int total);
    startTotal = total;
    startReq = 1;
    wait (startReq == 0);
    @(negedge clk); #3;
    while (mState != 0) begin @(negedge clk); #3; end
    repeat (3) @(negedge clk);
    #3;
  endtask

  initial begin
    int t0, d0, r0, f0, p0;
    repeat (4) @(negedge clk);
    #3;
    // R12: reset state
    chk(busy == 0, "R12", "busy in reset", busy, 0);
    chk(txValid == 0, "R12", "txValid in reset", txValid, 0);
    chk(srcReady == 0, "R12", "srcReady in reset", srcReady, 0);
    chk({respStart, reinitReq, faultReq, done} == 0, "R12", "pulses in reset",
        {respStart, reinitReq, faultReq, done}, 0);
    @(posedge clk); #1 rstN = 1'b1;
    repeat (2) @(negedge clk);

    // single short packet
    rxQ = '{8'h10}; runJob(5);
    chk(lastSent == 5, "R6", "sent after 5", lastSent, 5);
    // three packets 128/128/44
    rxQ = '{8'h10, 8'h10, 8'h10}; runJob(300);
    chk(lastSent == 300, "R5", "sent after 300", lastSent, 300);
    // exact chunk and chunk plus one odd byte
    rxQ = '{8'h10}; runJob(128);
    chk(lastSent == 128, "R2", "sent after 128", lastSent, 128);
    rxQ = '{8'h10, 8'h10}; runJob(129);
    chk(lastSent == 129, "R3", "sent after 129", lastSent, 129);
    // zero total
    t0 = txSeen; d0 = doneSeen;
    rxQ = {}; runJob(0);
    chk(txSeen == t0, "R11", "bytes sent for zero total", txSeen - t0, 0);
    chk(doneSeen == d0 + 1, "R11", "done count zero total", doneSeen - d0, 1);
    chk(lastSent == 0, "R11", "sentCount zero total", lastSent, 0);
    // early end after one packet
    p0 = preSeen;
    rxQ = '{8'h10, 8'h02}; runJob(200);
    chk(lastSent == 128, "R7", "sent at early end", lastSent, 128);
    chk(preSeen == p0 + 1, "R7", "preloaded pulses", preSeen - p0, 1);
    // reinit while waiting for the first continue
    r0 = reinitSeen;
    rxQ = '{8'h04}; runJob(50);
    chk(reinitSeen == r0 + 1, "R8", "reinit pulses", reinitSeen - r0, 1);
    chk(lastSent == 0, "R8", "sent at reinit", lastSent, 0);
    // unexpected byte after one packet
    f0 = faultSeen;
    rxQ = '{8'h10, 8'h33}; runJob(150);
    chk(faultSeen == f0 + 1, "R9", "fault pulses", faultSeen - f0, 1);
    chk(lastSent == 128, "R9", "sent at fault", lastSent, 128);
    // received noise while sending and idle is ignored
    r0 = reinitSeen;
    noiseOn = 1;
    rxQ = '{8'h10, 8'h10}; runJob(250);
    noiseOn = 0;
    chk(reinitSeen == r0, "R10", "reinit pulses under noise", reinitSeen - r0, 0);
    chk(lastSent == 250, "R10", "sent under noise", lastSent, 250);
    // start while busy is ignored
    busyStartReq = 1;
    rxQ = '{8'h10}; runJob(20);
    chk(lastSent == 20, "R10", "sent with start while busy", lastSent, 20);
    chk(busyStartReq == 0, "R10", "busy start issued", busyStartReq, 0);

    repeat (4) @(negedge clk);
    summary();
    $finish;
  end

endmodule